// File: doc/BRIEF.md
# Hardware Code Breakpoint Unit

This block holds four code breakpoint slots for a small CPU with a 16-bit instruction fetch address. A debug host programs a slot with a set-breakpoint frame: a one-cycle `set_cmd` pulse, then three bytes delivered on a byte-wide valid/ready input. The first byte chooses the slot and its enable. The next two bytes carry the high and low halves of the code address.

Every cycle the current fetch address is compared with all enabled slots. A match raises a registered, sticky halt request toward the CPU, together with the index of the slot that hit. The halt stays up until the host sends a resume pulse. A debug-enable input acts as a lock: when it is low, frames are still consumed but no slot changes. A frame whose reserved bits are not zero is thrown away, and a sticky error flag records it.

Top module: `bkpt_unit`

## Requirements
- R1: Four independent slots, indices 0 to 3, exist. When several enabled slots match the fetch address in the same cycle, `halt_slot` reports the lowest index.
- R2: A frame starts with a `set_cmd` pulse while idle. It then takes exactly three accepted bytes (`byte_valid && byte_ready`). Byte 1 carries bits 4:3 = slot index and bit 2 = enable (1 = on); its bits 7:5 are ignored. Byte 2 is address bits 15:8 and byte 3 is address bits 7:0. `byte_ready` is high only while a frame is waiting for bytes.
- R3: A slot changes only on the clock edge that accepts byte 3. After only one or two bytes, the slot still behaves as before.
- R4: When an enabled slot's address equals `fetch_addr`, `halt` is high in the next cycle.
- R5: Once `halt` is set, it stays high until a cycle with `resume` high and no match. A resume in a cycle that has a new match keeps `halt` set.
- R6: While `dbg_en` is 0 at the acceptance of byte 3, the frame is consumed and no slot changes.
- R7: If byte 1 bits 1:0 are not 00, the frame is consumed, no slot changes, and `frame_err` goes high and stays high until reset.
- R8: After reset all slots are disabled with address 0, `halt`, `halt_slot` and `frame_err` are 0, and no frame is in progress (`byte_ready` = 0).
- R9: A disabled slot never causes a halt, whatever its stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_cmd | input | 1 | Pulse that opens a set-breakpoint frame |
| byte_valid | input | 1 | Host byte is valid |
| byte_data | input | 8 | Host frame byte |
| byte_ready | output | 1 | Block accepts a frame byte |
| dbg_en | input | 1 | 1 = debug commands allowed, 0 = locked |
| fetch_addr | input | 16 | Current CPU code fetch address |
| resume | input | 1 | Clears the halt when no match is present |
| halt | output | 1 | Sticky halt request to the CPU |
| halt_slot | output | 2 | Slot index that caused the halt |
| frame_err | output | 1 | Sticky error for a frame with bad reserved bits |

## Verification
Assertions check on every cycle that a match is followed by halt, that halt holds without a clearing resume, that a resume with no match drops it, that slot contents stay frozen unless a write occurs, that the error flag never falls, and that the frame closes after its third byte. Only the bench scenarios can show that decoded fields land in the right slot, that priority picks the lowest index, that partial, locked and malformed frames leave slots untouched, and that the reported index matches the winner across a sweep of fetch addresses.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int BK_ADDR_W = 16;
    localparam int BK_SLOTS  = 4;
    localparam int BK_IDX_W  = $clog2(BK_SLOTS);

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_B1   = 2'd1,
        FR_B2   = 2'd2,
        FR_B3   = 2'd3
    } frame_st_t;

    typedef struct packed {
        logic                 en;
        logic [BK_ADDR_W-1:0] addr;
    } slot_t;
endpackage

// File: rtl/bkpt_frame.sv
module bkpt_frame
    import bkpt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_cmd,
    input  logic                byte_valid,
    input  logic [7:0]          byte_data,
    input  logic                dbg_en,
    output logic                byte_ready,
    output logic                wr_en,
    output logic [BK_IDX_W-1:0] wr_idx,
    output slot_t               wr_slot,
    output logic                frame_err
);
    typedef struct packed {
        frame_st_t           st;
        logic [BK_IDX_W-1:0] idx;
        logic                en;
        logic                bad;
        logic [7:0]          hi;
        logic                err;
    } frame_reg_t;

    frame_reg_t r_q, r_d;
    logic       acc;
    logic       unused_hi_bits;

    assign unused_hi_bits = ^byte_data[7:5];
    assign byte_ready     = (r_q.st != FR_IDLE);
    assign acc            = byte_valid && byte_ready;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            FR_IDLE: if (set_cmd) r_d.st = FR_B1;
            FR_B1: if (acc) begin
                r_d.idx = byte_data[3 +: BK_IDX_W];
                r_d.en  = byte_data[2];
                r_d.bad = (byte_data[1:0] != 2'b00);
                r_d.st  = FR_B2;
            end
            FR_B2: if (acc) begin
                r_d.hi = byte_data;
                r_d.st = FR_B3;
            end
            FR_B3: if (acc) begin
                r_d.st = FR_IDLE;
                if (r_q.bad) r_d.err = 1'b1;
            end
            default: r_d.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wr_en        = (r_q.st == FR_B3) && acc && dbg_en && !r_q.bad;
    assign wr_idx       = r_q.idx;
    assign wr_slot.en   = r_q.en;
    assign wr_slot.addr = {r_q.hi, byte_data};
    assign frame_err    = r_q.err;

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
    assert_frame_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == FR_B3 && acc) |=> !byte_ready);
    assert_lock_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en |-> !wr_en);
endmodule

// File: rtl/bkpt_slots.sv
module bkpt_slots
    import bkpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [BK_IDX_W-1:0]  wr_idx,
    input  slot_t                wr_slot,
    input  logic [BK_ADDR_W-1:0] fetch_addr,
    output logic                 hit,
    output logic [BK_IDX_W-1:0]  hit_idx
);
    slot_t [BK_SLOTS-1:0] slot_q;
    logic  [BK_SLOTS-1:0] match;

    for (genvar g = 0; g < BK_SLOTS; g++) begin : g_slot
        slot_t s_d;
        always_comb begin
            s_d = slot_q[g];
            if (wr_en && (wr_idx == BK_IDX_W'(g))) s_d = wr_slot;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= s_d;
        end
        assign match[g] = slot_q[g].en && (slot_q[g].addr == fetch_addr);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = BK_SLOTS - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = BK_IDX_W'(i);
        end
    end

    assert_slots_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(slot_q));
endmodule

// File: rtl/bkpt_halt.sv
module bkpt_halt
    import bkpt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic [BK_IDX_W-1:0] hit_idx,
    input  logic                resume,
    output logic                halt,
    output logic [BK_IDX_W-1:0] halt_slot
);
    typedef struct packed {
        logic                halt;
        logic [BK_IDX_W-1:0] idx;
    } halt_reg_t;

    halt_reg_t h_q, h_d;

    always_comb begin
        h_d      = h_q;
        h_d.halt = hit || (h_q.halt && !resume);
        if (hit && (!h_q.halt || resume)) h_d.idx = hit_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign halt      = h_q.halt;
    assign halt_slot = h_q.idx;

    assert_hit_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> halt);
    assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !resume) |=> halt);
    assert_resume_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resume && !hit) |=> !halt);
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_cmd,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    output logic                 byte_ready,
    input  logic                 dbg_en,
    input  logic [BK_ADDR_W-1:0] fetch_addr,
    input  logic                 resume,
    output logic                 halt,
    output logic [BK_IDX_W-1:0]  halt_slot,
    output logic                 frame_err
);
    logic                wr_en;
    logic [BK_IDX_W-1:0] wr_idx;
    slot_t               wr_slot;
    logic                hit;
    logic [BK_IDX_W-1:0] hit_idx;

    bkpt_frame u_frame (
        .clk(clk), .rst_n(rst_n), .set_cmd(set_cmd),
        .byte_valid(byte_valid), .byte_data(byte_data), .dbg_en(dbg_en),
        .byte_ready(byte_ready), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_slot(wr_slot), .frame_err(frame_err)
    );

    bkpt_slots u_slots (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_slot(wr_slot), .fetch_addr(fetch_addr),
        .hit(hit), .hit_idx(hit_idx)
    );

    bkpt_halt u_halt (
        .clk(clk), .rst_n(rst_n), .hit(hit), .hit_idx(hit_idx),
        .resume(resume), .halt(halt), .halt_slot(halt_slot)
    );

    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> (!halt && !frame_err && !byte_ready));
endmodule

// File: tb/bkpt_unit_test.sv
module bkpt_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        set_cmd = 0;
    logic        byte_valid = 0;
    logic [7:0]  byte_data = 0;
    logic        byte_ready;
    logic        dbg_en = 1;
    logic [15:0] fetch_addr = 0;
    logic        resume = 0;
    logic        halt;
    logic [1:0]  halt_slot;
    logic        frame_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic        m_en [4];
    logic [15:0] m_addr [4];
    logic        e_halt = 0;
    logic [1:0]  e_idx = 0;

    always #2 clk = ~clk;

    bkpt_unit uut (
        .clk(clk), .rst_n(rst_n), .set_cmd(set_cmd), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_ready(byte_ready), .dbg_en(dbg_en),
        .fetch_addr(fetch_addr), .resume(resume), .halt(halt),
        .halt_slot(halt_slot), .frame_err(frame_err)
    );

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic mhit(input logic [15:0] a);
        for (int i = 0; i < 4; i++) if (m_en[i] && m_addr[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [1:0] mwin(input logic [15:0] a);
        for (int i = 0; i < 4; i++) if (m_en[i] && m_addr[i] == a) return 2'(i);
        return 2'd0;
    endfunction

    // present an address for one cycle, then compare against the model
    task automatic probe(input logic [15:0] a, input logic r, input string req);
        logic h;
        fetch_addr = a;
        resume = r;
        h = mhit(a);
        if (h && (!e_halt || r)) e_idx = mwin(a);
        e_halt = h || (e_halt && !r);
        @(negedge clk);
        check(req, int'(halt), int'(e_halt));
        if (e_halt) check(req, int'(halt_slot), int'(e_idx));
    endtask

    task automatic put_byte(input logic [7:0] b);
        check("R2 ready", int'(byte_ready), 1);
        byte_valid = 1;
        byte_data = b;
        @(negedge clk);
        byte_valid = 0;
    endtask

    // full frame, fetch parked on address 0 with resume held
    task automatic frame(input logic [1:0] idx, input logic en, input logic [1:0] rsv,
                         input logic [2:0] junk, input logic [15:0] a, input logic apply);
        fetch_addr = 0;
        resume = 1;
        set_cmd = 1;
        @(negedge clk);
        set_cmd = 0;
        put_byte({junk, idx, en, rsv});
        put_byte(a[15:8]);
        put_byte(a[7:0]);
        check("R2 ready low after frame", int'(byte_ready), 0);
        if (apply) begin
            m_en[idx] = en;
            m_addr[idx] = a;
        end
        e_halt = 0;
        resume = 0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_en[i] = 0;
            m_addr[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R8 halt", int'(halt), 0);
        check("R8 slot", int'(halt_slot), 0);
        check("R8 err", int'(frame_err), 0);
        check("R8 ready", int'(byte_ready), 0);
        probe(16'h0000, 0, "R8 disabled at zero");
        probe(16'h1234, 1, "R9 no enabled slot");

        // program all slots, junk in ignored bits 7:5
        for (int i = 0; i < 4; i++)
            frame(2'(i), 1'b1, 2'b00, 3'(5 + i), 16'h1234 + 16'(i) * 16'h1111, 1);

        // R4 R1 sweep
        for (int i = 0; i < 4; i++) begin
            probe(m_addr[i], 1, "R4 slot address");
            probe(m_addr[i] ^ 16'h0001, 1, "R4 neighbour");
            probe(m_addr[i] ^ 16'h8000, 1, "R4 high bit");
        end
        for (int k = 0; k < 256; k++) probe(16'(k) * 16'd257, 1, "R4 sweep");

        // R1 priority: slot 3 copies slot 1
        frame(2'd3, 1'b1, 2'b00, 3'd0, m_addr[1], 1);
        probe(m_addr[1], 1, "R1 lowest wins");
        check("R1 index", int'(halt_slot), 1);
        // R9: disable slot 1, slot 3 takes over
        frame(2'd1, 1'b0, 2'b00, 3'd0, m_addr[3], 1);
        probe(m_addr[3], 1, "R9 disabled slot skipped");
        check("R9 index", int'(halt_slot), 3);

        // R3 partial frame
        fetch_addr = 0;
        resume = 1;
        set_cmd = 1;
        @(negedge clk);
        set_cmd = 0;
        put_byte({3'd0, 2'd0, 1'b1, 2'b00});
        put_byte(8'hAB);
        e_halt = 0;
        probe(16'hAB00, 1, "R3 partial no new");
        probe(m_addr[0], 1, "R3 old still active");
        fetch_addr = 0;
        resume = 1;
        put_byte(8'hCD);
        m_addr[0] = 16'hABCD;
        e_halt = 0;
        probe(16'hABCD, 1, "R3 applied after third");
        probe(16'h1234, 1, "R3 old gone");

        // R6 lock
        dbg_en = 0;
        frame(2'd2, 1'b1, 2'b00, 3'd0, 16'h0F0F, 0);
        dbg_en = 1;
        probe(16'h0F0F, 1, "R6 locked frame ignored");
        probe(m_addr[2], 1, "R6 slot kept");
        check("R6 no err", int'(frame_err), 0);

        // R7 reserved bits
        frame(2'd0, 1'b1, 2'b01, 3'd0, 16'h5555, 0);
        check("R7 err set", int'(frame_err), 1);
        probe(16'h5555, 1, "R7 frame discarded");
        probe(16'hABCD, 1, "R7 slot kept");
        frame(2'd0, 1'b1, 2'b00, 3'd0, 16'h6666, 1);
        check("R7 err sticky", int'(frame_err), 1);
        probe(16'h6666, 1, "R7 later frame works");

        // R5 sticky halt
        probe(16'h0000, 1, "R5 clear");
        probe(m_addr[2], 0, "R5 set");
        for (int i = 0; i < 3; i++) probe(16'h0000, 0, "R5 holds");
        probe(m_addr[3], 1, "R5 resume with match");
        check("R5 index updated", int'(halt_slot), 3);
        probe(16'h0000, 1, "R5 resume clears");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule